// File: doc/BRIEF.md
# AUX Transaction Retry Controller

This block runs a single display auxiliary-channel transaction for a requester and retries it until it completes, fails or uses up its attempt budget. The requester gives the request kind (native or I2C-over-AUX, read or write), a target address and a byte count, then pulses start. The controller forwards the latched request to a transport port as a one-cycle issue pulse. It then waits for the transport's response: a busy flag, a generic error flag, a four-bit reply code and the number of bytes moved.

Each response is sorted into one of three outcomes: finish, retry at once, or wait for a deferral interval and retry. Deferral intervals are counted on a one-microsecond tick input. The wait length depends on whether the deferral came from the native reply field or from the I2C reply field. When the transaction finishes, the controller pulses done for one cycle and presents a result code, and the byte count when the result is success. A transaction that keeps being retried is cut off after a fixed number of attempts.

Top module: `aux_retry_ctrl`

## Requirements
- R1: A start accepted while idle latches the kind, direction, address and size, and issues one single-cycle transport pulse carrying them; later changes on the request inputs do not alter the fields shown on any retry of that transaction.
- R2: At most 7 transport attempts are made. If the seventh attempt ends in a retry or deferral outcome, the result is IO (2) for a native transaction or REMOTEIO (3) for an I2C-over-AUX one.
- R3: A response with the busy flag set takes precedence over the error flag, uses up an attempt and leads to the next issue pulse with no tick wait.
- R4: A response with the error flag set and busy clear ends the transaction at once with TRANSPORT (4).
- R5: The reply code holds a native field in bits [1:0] and an I2C field in bits [3:2], each coded 0 acknowledge, 1 refuse, 2 defer, 3 invalid. A native transaction that gets native acknowledge ends with OK (0) if the bytes moved equal the requested size, and with PROTO (1) if fewer bytes moved. The count output shows the bytes moved on OK and zero on any other result.
- R6: A native transaction that gets native refuse ends with IO (2). One that gets the invalid native code retries at once without a wait.
- R7: A native transaction that gets native defer waits 400 ticks before the next attempt.
- R8: An I2C-over-AUX transaction that gets native refuse or native invalid ends with REMOTEIO (3). One that gets native defer waits 500 ticks before the next attempt.
- R9: An I2C-over-AUX transaction that gets native acknowledge is decided by the I2C field. Acknowledge gives OK with the full count and PROTO with a short count. Refuse or invalid gives REMOTEIO. Defer waits 400 ticks before the next attempt.
- R10: Done is a single-cycle pulse, one for each accepted start. A start presented in the done cycle is accepted.
- R11: A start presented while a transaction is in progress is ignored: it produces no extra issue pulse and no extra done pulse.
- R12: A deferral on the final attempt ends the transaction in the next cycle with the exhaustion result, without waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_us_i | input | 1 | One-cycle pulse every microsecond |
| req_start_i | input | 1 | Start a transaction (taken while idle) |
| req_i2c_i | input | 1 | 1 = I2C-over-AUX, 0 = native |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Target address |
| req_size_i | input | SIZE_W | Requested byte count |
| done_o | output | 1 | Transaction finished (one cycle) |
| result_o | output | 3 | 0 OK, 1 PROTO, 2 IO, 3 REMOTEIO, 4 TRANSPORT |
| count_o | output | SIZE_W | Bytes moved on OK, else zero |
| xfer_issue_o | output | 1 | One-cycle attempt pulse to the transport |
| xfer_i2c_o | output | 1 | Latched transaction kind |
| xfer_write_o | output | 1 | Latched direction |
| xfer_addr_o | output | ADDR_W | Latched address |
| xfer_size_o | output | SIZE_W | Latched size |
| xfer_done_i | input | 1 | Transport response valid (one cycle) |
| xfer_busy_i | input | 1 | Transport busy error |
| xfer_err_i | input | 1 | Other transport error |
| xfer_reply_i | input | 4 | Reply code, native [1:0], I2C [3:2] |
| xfer_count_i | input | SIZE_W | Bytes moved by the attempt |

## Verification
Deferral handling and budget exhaustion can fall on the same response. When the seventh attempt returns a defer code, the classifier asks for a wait while the attempt counter says the budget is spent. The bench provokes this with seven I2C defers, and separately with six busy responses followed by a native defer. It then judges that done follows the final response within two cycles and carries the exhaustion code, instead of a 400- or 500-tick wait. A second overlap, a new start in the done cycle, is driven back to back and scored as two separate transactions.

// File: rtl/aux_retry_pkg.sv
package aux_retry_pkg;

  typedef enum logic [2:0] {
    RES_OK        = 3'd0,
    RES_PROTO     = 3'd1,
    RES_IO        = 3'd2,
    RES_REMOTEIO  = 3'd3,
    RES_TRANSPORT = 3'd4
  } aux_res_e;

  typedef enum logic [1:0] {
    ACT_FINISH = 2'd0,
    ACT_RETRY  = 2'd1,
    ACT_DEFER  = 2'd2
  } aux_act_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SEND  = 2'd1,
    ST_RESP  = 2'd2,
    ST_DEFER = 2'd3
  } aux_st_e;

  // reply field coding, same for native [1:0] and I2C [3:2]
  localparam logic [1:0] RC_ACK   = 2'd0;
  localparam logic [1:0] RC_NACK  = 2'd1;
  localparam logic [1:0] RC_DEFER = 2'd2;

endpackage

// File: rtl/aux_reply_classify.sv
module aux_reply_classify
  import aux_retry_pkg::*;
#(
  parameter int SIZE_W              = 5,
  parameter int WAIT_W              = 9,
  parameter int NATIVE_DEFER_US     = 400,
  parameter int I2C_NATIVE_DEFER_US = 500,
  parameter int I2C_DEFER_US        = 400
) (
  input  logic              i2c_i,
  input  logic              busy_i,
  input  logic              err_i,
  input  logic [3:0]        reply_i,
  input  logic [SIZE_W-1:0] got_i,
  input  logic [SIZE_W-1:0] want_i,
  output aux_act_e          act_o,
  output aux_res_e          res_o,
  output logic [WAIT_W-1:0] wait_o
);

  logic [1:0] nat_rc, i2c_rc;
  logic       short_cnt;

  assign nat_rc    = reply_i[1:0];
  assign i2c_rc    = reply_i[3:2];
  assign short_cnt = got_i < want_i;

  always_comb begin
    act_o  = ACT_FINISH;
    res_o  = RES_REMOTEIO;
    wait_o = '0;
    if (busy_i) begin
      act_o = ACT_RETRY;
    end else if (err_i) begin
      res_o = RES_TRANSPORT;
    end else if (!i2c_i) begin
      unique case (nat_rc)
        RC_ACK:   res_o = short_cnt ? RES_PROTO : RES_OK;
        RC_NACK:  res_o = RES_IO;
        RC_DEFER: begin
          act_o  = ACT_DEFER;
          wait_o = WAIT_W'(NATIVE_DEFER_US);
        end
        default:  act_o = ACT_RETRY;  // unknown native code: plain retry
      endcase
    end else begin
      unique case (nat_rc)
        RC_ACK: begin
          unique case (i2c_rc)
            RC_ACK:   res_o = short_cnt ? RES_PROTO : RES_OK;
            RC_DEFER: begin
              act_o  = ACT_DEFER;
              wait_o = WAIT_W'(I2C_DEFER_US);
            end
            default:  res_o = RES_REMOTEIO;
          endcase
        end
        RC_DEFER: begin
          act_o  = ACT_DEFER;
          wait_o = WAIT_W'(I2C_NATIVE_DEFER_US);
        end
        default: res_o = RES_REMOTEIO;
      endcase
    end
  end

endmodule

// File: rtl/aux_defer_timer.sv
module aux_defer_timer #(
  parameter int WAIT_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WAIT_W-1:0] len_i,
  input  logic              tick_i,
  output logic              expired_o
);

  logic [WAIT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (load_i)              cnt_q <= len_i;
    else if (tick_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/aux_attempt_budget.sv
module aux_attempt_budget #(
  parameter int MAX_ATTEMPTS = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);

  localparam int CNT_W = $clog2(MAX_ATTEMPTS + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = (cnt_q >= CNT_W'(MAX_ATTEMPTS));

endmodule

// File: rtl/aux_retry_ctrl.sv
module aux_retry_ctrl
  import aux_retry_pkg::*;
#(
  parameter int ADDR_W              = 20,
  parameter int SIZE_W              = 5,
  parameter int MAX_ATTEMPTS        = 7,
  parameter int NATIVE_DEFER_US     = 400,
  parameter int I2C_NATIVE_DEFER_US = 500,
  parameter int I2C_DEFER_US        = 400
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_us_i,
  input  logic              req_start_i,
  input  logic              req_i2c_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [SIZE_W-1:0] req_size_i,
  output logic              done_o,
  output logic [2:0]        result_o,
  output logic [SIZE_W-1:0] count_o,
  output logic              xfer_issue_o,
  output logic              xfer_i2c_o,
  output logic              xfer_write_o,
  output logic [ADDR_W-1:0] xfer_addr_o,
  output logic [SIZE_W-1:0] xfer_size_o,
  input  logic              xfer_done_i,
  input  logic              xfer_busy_i,
  input  logic              xfer_err_i,
  input  logic [3:0]        xfer_reply_i,
  input  logic [SIZE_W-1:0] xfer_count_i
);

  localparam int MAX_A    = (NATIVE_DEFER_US > I2C_DEFER_US) ? NATIVE_DEFER_US : I2C_DEFER_US;
  localparam int MAX_WAIT = (MAX_A > I2C_NATIVE_DEFER_US) ? MAX_A : I2C_NATIVE_DEFER_US;
  localparam int WAIT_W   = $clog2(MAX_WAIT + 1);

  aux_st_e           state_q, state_d;
  logic              i2c_q, write_q;
  logic [ADDR_W-1:0] addr_q;
  logic [SIZE_W-1:0] size_q;
  logic              done_q;
  aux_res_e          res_q;
  logic [SIZE_W-1:0] cnt_q;

  aux_act_e          act;
  aux_res_e          cls_res;
  logic [WAIT_W-1:0] wait_len;
  logic              att_last, tmr_expired, tmr_load;
  logic              accept, fin;
  aux_res_e          fin_res;
  logic [SIZE_W-1:0] fin_cnt;

  assign accept = (state_q == ST_IDLE) && req_start_i;

  aux_reply_classify #(
    .SIZE_W              (SIZE_W),
    .WAIT_W              (WAIT_W),
    .NATIVE_DEFER_US     (NATIVE_DEFER_US),
    .I2C_NATIVE_DEFER_US (I2C_NATIVE_DEFER_US),
    .I2C_DEFER_US        (I2C_DEFER_US)
  ) u_classify (
    .i2c_i   (i2c_q),
    .busy_i  (xfer_busy_i),
    .err_i   (xfer_err_i),
    .reply_i (xfer_reply_i),
    .got_i   (xfer_count_i),
    .want_i  (size_q),
    .act_o   (act),
    .res_o   (cls_res),
    .wait_o  (wait_len)
  );

  aux_defer_timer #(.WAIT_W(WAIT_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (tmr_load),
    .len_i     (wait_len),
    .tick_i    (tick_us_i),
    .expired_o (tmr_expired)
  );

  aux_attempt_budget #(.MAX_ATTEMPTS(MAX_ATTEMPTS)) u_budget (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (accept),
    .inc_i  (state_q == ST_SEND),
    .last_o (att_last)
  );

  always_comb begin
    state_d  = state_q;
    fin      = 1'b0;
    fin_res  = cls_res;
    fin_cnt  = '0;
    tmr_load = 1'b0;
    unique case (state_q)
      ST_IDLE:  if (req_start_i) state_d = ST_SEND;
      ST_SEND:  state_d = ST_RESP;
      ST_RESP: begin
        if (xfer_done_i) begin
          if (act == ACT_FINISH) begin
            fin     = 1'b1;
            fin_cnt = (cls_res == RES_OK) ? xfer_count_i : '0;
            state_d = ST_IDLE;
          end else if (att_last) begin
            // budget spent: a pending defer is not waited out
            fin     = 1'b1;
            fin_res = i2c_q ? RES_REMOTEIO : RES_IO;
            state_d = ST_IDLE;
          end else if (act == ACT_RETRY) begin
            state_d = ST_SEND;
          end else begin
            tmr_load = 1'b1;
            state_d  = ST_DEFER;
          end
        end
      end
      ST_DEFER: if (tmr_expired) state_d = ST_SEND;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      i2c_q   <= 1'b0;
      write_q <= 1'b0;
      addr_q  <= '0;
      size_q  <= '0;
      done_q  <= 1'b0;
      res_q   <= RES_OK;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= fin;
      if (accept) begin
        i2c_q   <= req_i2c_i;
        write_q <= req_write_i;
        addr_q  <= req_addr_i;
        size_q  <= req_size_i;
      end
      if (fin) begin
        res_q <= fin_res;
        cnt_q <= fin_cnt;
      end
    end
  end

  assign done_o       = done_q;
  assign result_o     = res_q;
  assign count_o      = cnt_q;
  assign xfer_issue_o = (state_q == ST_SEND);
  assign xfer_i2c_o   = i2c_q;
  assign xfer_write_o = write_q;
  assign xfer_addr_o  = addr_q;
  assign xfer_size_o  = size_q;

endmodule

// File: rtl/aux_retry_ctrl_chk.sv
module aux_retry_ctrl_chk
  import aux_retry_pkg::*;
#(
  parameter int SIZE_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input aux_st_e           state_i,
  input logic              att_last_i,
  input logic              done_o,
  input logic [2:0]        result_o,
  input logic [SIZE_W-1:0] count_o,
  input logic              xfer_issue_o,
  input logic              xfer_i2c_o,
  input logic              xfer_done_i,
  input logic              xfer_busy_i,
  input logic              xfer_err_i,
  input logic [3:0]        xfer_reply_i
);

  logic resp_seen;
  assign resp_seen = (state_i == ST_RESP) && xfer_done_i;

  p_issue_pulse_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_issue_o |=> !xfer_issue_o);

  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_result_legal_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> result_o <= 3'd4);

  p_count_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && result_o != 3'd0) |-> count_o == '0);

  p_xport_err_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_seen && !xfer_busy_i && xfer_err_i) |=> (done_o && result_o == 3'd4));

  p_busy_retry_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_seen && xfer_busy_i && !att_last_i) |=> xfer_issue_o);

  p_exhaust_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_seen && xfer_busy_i && att_last_i) |=>
      (done_o && (result_o == 3'd2 || result_o == 3'd3)));

  p_last_defer_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_seen && !xfer_busy_i && !xfer_err_i && !xfer_i2c_o &&
     xfer_reply_i[1:0] == 2'd2 && att_last_i) |=> (done_o && result_o == 3'd2));

endmodule

bind aux_retry_ctrl aux_retry_ctrl_chk #(.SIZE_W(SIZE_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .state_i      (state_q),
  .att_last_i   (att_last),
  .done_o       (done_o),
  .result_o     (result_o),
  .count_o      (count_o),
  .xfer_issue_o (xfer_issue_o),
  .xfer_i2c_o   (xfer_i2c_o),
  .xfer_done_i  (xfer_done_i),
  .xfer_busy_i  (xfer_busy_i),
  .xfer_err_i   (xfer_err_i),
  .xfer_reply_i (xfer_reply_i)
);

// File: tb/aux_retry_ctrl_tb_top.sv
module aux_retry_ctrl_tb_top;

  localparam int ADDR_W = 20;
  localparam int SIZE_W = 5;
  localparam int LAT    = 2;
  localparam int W_NAT  = 400;
  localparam int W_I2CN = 500;
  localparam int W_I2C  = 400;

  // kind: 0 reply, 1 busy, 2 generic error
  typedef struct packed {
    logic [1:0]        kind;
    logic [3:0]        reply;
    logic [SIZE_W-1:0] cnt;
  } rsp_t;

  typedef struct packed {
    logic [2:0]        res;
    logic [SIZE_W-1:0] cnt;
    logic [3:0]        att;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic start = 1'b0, r_i2c = 1'b0, r_wr = 1'b0;
  logic [ADDR_W-1:0] r_addr = '0;
  logic [SIZE_W-1:0] r_size = '0;
  logic done, issue, x_i2c, x_wr;
  logic [2:0] result;
  logic [SIZE_W-1:0] count, x_size;
  logic [ADDR_W-1:0] x_addr;
  logic x_done = 1'b0, x_busy = 1'b0, x_err = 1'b0;
  logic [3:0] x_reply = '0;
  logic [SIZE_W-1:0] x_cnt = '0;

  always #10 clk = ~clk;

  aux_retry_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_us_i(tick),
    .req_start_i(start), .req_i2c_i(r_i2c), .req_write_i(r_wr),
    .req_addr_i(r_addr), .req_size_i(r_size),
    .done_o(done), .result_o(result), .count_o(count),
    .xfer_issue_o(issue), .xfer_i2c_o(x_i2c), .xfer_write_o(x_wr),
    .xfer_addr_o(x_addr), .xfer_size_o(x_size),
    .xfer_done_i(x_done), .xfer_busy_i(x_busy), .xfer_err_i(x_err),
    .xfer_reply_i(x_reply), .xfer_count_i(x_cnt)
  );

  int checks = 0, fails = 0;
  rsp_t  scr[$];
  rsp_t  tq[$];
  exp_t  exp_q[$];
  string tag_q[$];
  logic cur_i2c = 1'b0, cur_wr = 1'b0;
  logic [ADDR_W-1:0] cur_addr = '0;
  logic [SIZE_W-1:0] cur_size = '0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic rsp_t mk(input logic [1:0] k, input logic [3:0] rc,
                              input logic [SIZE_W-1:0] n);
    rsp_t r;
    r.kind = k; r.reply = rc; r.cnt = n;
    return r;
  endfunction

  // expected outcome from the requirement rules
  function automatic exp_t model(input bit i2c, input logic [SIZE_W-1:0] sz);
    exp_t e;
    e.res = i2c ? 3'd3 : 3'd2;
    e.cnt = '0;
    e.att = 4'd7;
    for (int k = 0; k < 7; k++) begin
      rsp_t r;
      if (k >= scr.size()) break;
      r = scr[k];
      e.att = 4'(k + 1);
      if (r.kind == 2'd1) continue;
      if (r.kind == 2'd2) begin e.res = 3'd4; return e; end
      if (!i2c) begin
        if (r.reply[1:0] == 2'd0) begin
          e.res = (r.cnt < sz) ? 3'd1 : 3'd0;
          e.cnt = (r.cnt < sz) ? '0 : r.cnt;
          return e;
        end
        if (r.reply[1:0] == 2'd1) begin e.res = 3'd2; return e; end
      end else begin
        if (r.reply[1:0] == 2'd1 || r.reply[1:0] == 2'd3) begin e.res = 3'd3; return e; end
        if (r.reply[1:0] == 2'd0) begin
          if (r.reply[3:2] == 2'd0) begin
            e.res = (r.cnt < sz) ? 3'd1 : 3'd0;
            e.cnt = (r.cnt < sz) ? '0 : r.cnt;
            return e;
          end
          if (r.reply[3:2] != 2'd2) begin e.res = 3'd3; return e; end
        end
      end
    end
    e.res = i2c ? 3'd3 : 3'd2;
    e.cnt = '0;
    e.att = 4'd7;
    return e;
  endfunction

  // -1 terminal, 0 immediate retry, else ticks to wait
  function automatic int wait_of(input bit i2c, input rsp_t r);
    if (r.kind == 2'd1) return 0;
    if (r.kind == 2'd2) return -1;
    if (!i2c) begin
      if (r.reply[1:0] == 2'd2) return W_NAT;
      if (r.reply[1:0] == 2'd3) return 0;
      return -1;
    end
    if (r.reply[1:0] == 2'd2) return W_I2CN;
    if (r.reply[1:0] == 2'd0 && r.reply[3:2] == 2'd2) return W_I2C;
    return -1;
  endfunction

  // transport model and scoreboard monitor
  int   resp_delay = 0, pend_wait = -1, gap_cyc = 0, gap_tick = 0;
  int   issue_cnt = 0, done_cnt = 0;
  bit   prev_done = 1'b0;
  rsp_t cur_rsp;

  always @(negedge clk) begin
    if (rst_n) begin
      tick = ~tick;
      gap_cyc++;
      if (tick) gap_tick++;
      x_done = 1'b0;
      if (resp_delay > 0) begin
        resp_delay--;
        if (resp_delay == 0) begin
          x_done  = 1'b1;
          x_busy  = (cur_rsp.kind == 2'd1);
          x_err   = (cur_rsp.kind == 2'd2);
          x_reply = cur_rsp.reply;
          x_cnt   = cur_rsp.cnt;
          pend_wait = wait_of(cur_i2c, cur_rsp);
          gap_cyc = 0;
          gap_tick = 0;
        end
      end
      if (done) begin
        chk(!prev_done, "R10", "done pulse width", 2, 1);
        if (pend_wait >= 0) chk(gap_cyc <= 2, "R12", "cycles to done after final retry", gap_cyc, 1);
        pend_wait = -1;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R11", "unexpected done", 1, 0);
        end else begin
          exp_t  e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(result == e.res, t, "result", int'(result), int'(e.res));
          chk(count == e.cnt, t, "count", int'(count), int'(e.cnt));
          chk(issue_cnt == int'(e.att), t, "attempts", issue_cnt, int'(e.att));
        end
        issue_cnt = 0;
        done_cnt++;
      end
      prev_done = done;
      if (issue) begin
        if (pend_wait == 0) begin
          chk(gap_cyc <= 2, "R3", "cycles to immediate retry", gap_cyc, 1);
        end else if (pend_wait > 0) begin
          string wt;
          wt = !cur_i2c ? "R7" : (pend_wait == W_I2CN ? "R8" : "R9");
          chk(gap_tick >= pend_wait - 1 && gap_tick <= pend_wait + 1, wt,
              "ticks waited", gap_tick, pend_wait);
        end
        pend_wait = -1;
        chk(x_i2c == cur_i2c && x_wr == cur_wr && x_addr == cur_addr && x_size == cur_size,
            "R1", "forwarded address", int'(x_addr), int'(cur_addr));
        if (tq.size() == 0) begin
          chk(1'b0, "R11", "issue with no scripted response", 1, 0);
          cur_rsp = mk(2'd2, 4'd0, '0);
        end else begin
          cur_rsp = tq.pop_front();
        end
        issue_cnt++;
        resp_delay = LAT;
      end
    end
  end

  // driver: call at a negedge
  task automatic launch(input bit i2c, input bit wr, input logic [ADDR_W-1:0] a,
                        input logic [SIZE_W-1:0] sz, input string tag);
    exp_q.push_back(model(i2c, sz));
    tag_q.push_back(tag);
    foreach (scr[k]) tq.push_back(scr[k]);
    scr.delete();
    cur_i2c = i2c; cur_wr = wr; cur_addr = a; cur_size = sz;
    start = 1'b1; r_i2c = i2c; r_wr = wr; r_addr = a; r_size = sz;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    int target;
    target = done_cnt + 1;
    while (done_cnt < target) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic txn(input bit i2c, input bit wr, input logic [ADDR_W-1:0] a,
                     input logic [SIZE_W-1:0] sz, input string tag);
    launch(i2c, wr, a, sz, tag);
    wait_done();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(done == 1'b0, "R10", "done in reset", int'(done), 0);
    chk(issue == 1'b0, "R1", "issue in reset", int'(issue), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    scr.push_back(mk(0, 4'h0, 5'd4));                     txn(0, 1, 20'h00100, 5'd4, "R5");
    scr.push_back(mk(0, 4'h0, 5'd2));                     txn(0, 0, 20'h00202, 5'd4, "R5");
    scr.push_back(mk(0, 4'h1, 5'd0));                     txn(0, 0, 20'h00600, 5'd1, "R6");
    scr.push_back(mk(0, 4'h2, 5'd0)); scr.push_back(mk(0, 4'h0, 5'd3));
                                                          txn(0, 0, 20'h00000, 5'd3, "R7");
    scr.push_back(mk(0, 4'h3, 5'd0)); scr.push_back(mk(0, 4'h0, 5'd1));
                                                          txn(0, 1, 20'h00107, 5'd1, "R6");
    scr.push_back(mk(1, 4'h0, 5'd0)); scr.push_back(mk(1, 4'h0, 5'd0));
    scr.push_back(mk(0, 4'h0, 5'd2));                     txn(0, 0, 20'h00300, 5'd2, "R3");
    scr.push_back(mk(2, 4'h0, 5'd0));                     txn(0, 0, 20'h00310, 5'd2, "R4");
    for (int k = 0; k < 7; k++) scr.push_back(mk(1, 4'h0, 5'd0));
                                                          txn(0, 0, 20'h00320, 5'd2, "R2");
    scr.push_back(mk(0, 4'h0, 5'd1));                     txn(1, 0, 20'h00050, 5'd1, "R9");
    scr.push_back(mk(0, 4'h0, 5'd0));                     txn(1, 0, 20'h00050, 5'd1, "R9");
    scr.push_back(mk(0, 4'h1, 5'd0));                     txn(1, 1, 20'h00050, 5'd1, "R8");
    scr.push_back(mk(0, 4'h3, 5'd0));                     txn(1, 0, 20'h00051, 5'd1, "R8");
    scr.push_back(mk(0, 4'h2, 5'd0)); scr.push_back(mk(0, 4'h0, 5'd1));
                                                          txn(1, 0, 20'h00052, 5'd1, "R8");
    scr.push_back(mk(0, 4'h8, 5'd0)); scr.push_back(mk(0, 4'h0, 5'd1));
                                                          txn(1, 1, 20'h00053, 5'd1, "R9");
    scr.push_back(mk(0, 4'h4, 5'd0));                     txn(1, 0, 20'h00054, 5'd1, "R9");
    scr.push_back(mk(0, 4'hC, 5'd0));                     txn(1, 0, 20'h00055, 5'd1, "R9");
    for (int k = 0; k < 7; k++) scr.push_back(mk(0, 4'h8, 5'd0));
                                                          txn(1, 0, 20'h00056, 5'd1, "R12");
    for (int k = 0; k < 6; k++) scr.push_back(mk(1, 4'h0, 5'd0));
    scr.push_back(mk(0, 4'h2, 5'd0));                     txn(0, 0, 20'h00330, 5'd1, "R12");

    // start during a defer wait must be ignored
    scr.push_back(mk(0, 4'h2, 5'd0)); scr.push_back(mk(0, 4'h0, 5'd2));
    @(negedge clk);
    launch(0, 0, 20'h00400, 5'd2, "R11");
    repeat (40) @(negedge clk);
    start = 1'b1; r_i2c = 1'b1; r_wr = 1'b1; r_addr = 20'hABCDE; r_size = 5'd9;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    repeat (20) @(negedge clk);

    // back-to-back: second start in the done cycle
    scr.push_back(mk(0, 4'h0, 5'd3));
    @(negedge clk);
    launch(0, 1, 20'h00500, 5'd3, "R10");
    while (!done) @(negedge clk);
    scr.push_back(mk(0, 4'h1, 5'd0));
    launch(0, 0, 20'h00510, 5'd3, "R10");
    wait_done();
    repeat (20) @(negedge clk);

    chk(exp_q.size() == 0, "R11", "outstanding results", exp_q.size(), 0);
    chk(tq.size() == 0, "R11", "unused responses", tq.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule